// File: doc/BRIEF.md
# Exception State Register Unit

This unit holds the architectural state that a processor's control logic consults and updates when normal instruction flow is interrupted. It contains four registers: a status word with an interrupt mask and a three-level stack of privilege/enable pairs, a cause word with latched interrupt requests and an exception code, a saved-PC register, and a faulting-address register. A single-cycle exception request captures the PC, the code and, when flagged, the faulting data address, and enters kernel mode with interrupts disabled. A return request unwinds the mode stack by one level.

Hardware interrupt lines are latched into sticky pending flags. The unit raises an interrupt-take signal when an unmasked flag is pending and the current enable bit is set. Software reads any register through a select-driven read port and writes through a single write port. The status update is chosen by a named operation (`MODE_HOLD`, `MODE_PUSH`, `MODE_POP`, `MODE_LOAD`), with priority push over pop over load. Register selects are named `SEL_STATUS`, `SEL_CAUSE`, `SEL_EPC` and `SEL_BADADDR`.

Top module: `exc_regs_unit`

## Requirements
- R1: After reset all four registers read as zero (kernel mode, interrupts disabled, nothing pending) and `irq_take_o` is low.
- R2: An exception request shifts status bits 5:0 left by two and clears bits 1:0. Bits 1:0 form the current pair (bit 0 interrupt enable, bit 1 user mode), bits 3:2 the previous pair and bits 5:4 the oldest pair.
- R3: A return request without an exception sets status bits 3:0 to the old bits 5:2 and leaves bits 5:4 unchanged.
- R4: An exception loads the saved-PC register with `pc_next_i` minus 4, modulo 2^32, and writes `exc_code_i` into cause bits 5:2.
- R5: The faulting-address register loads `bad_addr_i` only on an exception with `bad_vld_i` high. Otherwise it holds its value.
- R6: Cause bits 15:10 are pending flags for `irq_i[5:0]`. A flag sets when its line is high, even with interrupts disabled. It clears only when software writes 0 to that bit of cause, and a line that is high in the same cycle wins.
- R7: `irq_take_o` is high when status bit 0 is set and any of cause bits 15:8 is set where the matching status mask bit (bits 15:8) is also set.
- R8: Software writes take effect as follows. Status (select 0) takes bits 15:8 and 5:0 and reads zero elsewhere. Cause (select 1) takes bits 9:8 as software-pending flags, and its code field is read-only. The saved PC (select 2) takes all 32 bits. Writes to the faulting address (select 3) are ignored.
- R9: An exception overrides a same-cycle return request and any same-cycle software write to status, cause or saved PC. A return request overrides a same-cycle software write to status.
- R10: `rd_data_o` shows status, cause, saved PC or faulting address for `rd_sel_i` values 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Exception entry request, one cycle |
| exc_code_i | input | 4 | Exception code to record |
| pc_next_i | input | 32 | Incremented PC of the offending instruction |
| bad_vld_i | input | 1 | Faulting data address is valid |
| bad_addr_i | input | 32 | Faulting data address |
| rfe_i | input | 1 | Return-from-exception request |
| irq_i | input | 6 | Hardware interrupt request lines |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 2 | Software write register select |
| sw_wdata_i | input | 32 | Software write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Read data |
| irq_take_o | output | 1 | Interrupt should be taken |

## Verification
The bench uses the default parameters: 32-bit addresses, six hardware levels, two software levels and a 4-bit code. These values make every state of the 6-bit mode stack reachable, so both push and pop are swept over all 64 values. They also make the interrupt-take sweep complete: all 256 pending patterns are checked against all 256 mask values. Every code value and the wrap of the PC-minus-4 subtraction at zero are covered, along with each pairing of simultaneous exception, return and software write.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_CAUSE   = 2'd1,
        SEL_EPC     = 2'd2,
        SEL_BADADDR = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_HOLD,
        MODE_PUSH,
        MODE_POP,
        MODE_LOAD
    } mode_op_e;

    localparam int STACK_W = 6;
    localparam int MASK_LO = 8;
    localparam int PEND_LO = 8;
    localparam int CODE_LO = 2;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_pkg::*;
#(
    parameter int LEVELS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req_i,
    input  logic               rfe_i,
    input  logic               wr_en_i,
    input  logic [LEVELS-1:0]  wr_mask_i,
    input  logic [STACK_W-1:0] wr_stack_i,
    output logic [LEVELS-1:0]  mask_o,
    output logic [STACK_W-1:0] stack_o
);
    mode_op_e           op;
    logic [LEVELS-1:0]  mask_q;
    logic [STACK_W-1:0] stack_q;

    always_comb begin
        if (exc_req_i)    op = MODE_PUSH;
        else if (rfe_i)   op = MODE_POP;
        else if (wr_en_i) op = MODE_LOAD;
        else              op = MODE_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            stack_q <= '0;
        end else begin
            unique case (op)
                MODE_PUSH: stack_q <= {stack_q[STACK_W-3:0], 2'b00};
                MODE_POP:  stack_q <= {stack_q[STACK_W-1 -: 2], stack_q[STACK_W-1:2]};
                MODE_LOAD: begin
                    mask_q  <= wr_mask_i;
                    stack_q <= wr_stack_i;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mask_o  = mask_q;
        stack_o = stack_q;
    end
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
    parameter int HW_IRQS = 6,
    parameter int SW_IRQS = 2,
    parameter int CODE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [HW_IRQS-1:0] irq_i,
    input  logic               wr_en_i,
    input  logic [HW_IRQS-1:0] wr_hw_i,
    input  logic [SW_IRQS-1:0] wr_sw_i,
    output logic [HW_IRQS-1:0] hw_pend_o,
    output logic [SW_IRQS-1:0] sw_pend_o,
    output logic [CODE_W-1:0]  code_o
);
    logic               wr_eff;
    logic [SW_IRQS-1:0] sw_q;
    logic [CODE_W-1:0]  code_q;

    assign wr_eff = wr_en_i & ~exc_req_i;

    for (genvar g = 0; g < HW_IRQS; g++) begin : g_level
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     flag_q <= 1'b0;
            else if (irq_i[g])              flag_q <= 1'b1;
            else if (wr_eff && !wr_hw_i[g]) flag_q <= 1'b0;
        end
        assign hw_pend_o[g] = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q   <= '0;
            code_q <= '0;
        end else begin
            if (wr_eff)    sw_q   <= wr_sw_i;
            if (exc_req_i) code_q <= code_i;
        end
    end

    assign sw_pend_o = sw_q;
    assign code_o    = code_q;
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req_i,
    input  logic [ADDR_W-1:0] pc_next_i,
    input  logic              bad_vld_i,
    input  logic [ADDR_W-1:0] bad_addr_i,
    input  logic              epc_we_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [ADDR_W-1:0] epc_o,
    output logic [ADDR_W-1:0] bad_o
);
    logic [ADDR_W-1:0] epc_q, bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q <= '0;
            bad_q <= '0;
        end else begin
            if (exc_req_i)     epc_q <= pc_next_i - ADDR_W'(4);
            else if (epc_we_i) epc_q <= wr_data_i;
            if (exc_req_i && bad_vld_i) bad_q <= bad_addr_i;
        end
    end

    assign epc_o = epc_q;
    assign bad_o = bad_q;
endmodule

// File: rtl/exc_regs_unit.sv
module exc_regs_unit
    import exc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int HW_IRQS = 6,
    parameter int SW_IRQS = 2,
    parameter int CODE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req_i,
    input  logic [CODE_W-1:0]  exc_code_i,
    input  logic [ADDR_W-1:0]  pc_next_i,
    input  logic               bad_vld_i,
    input  logic [ADDR_W-1:0]  bad_addr_i,
    input  logic               rfe_i,
    input  logic [HW_IRQS-1:0] irq_i,
    input  logic               sw_we_i,
    input  logic [1:0]         sw_sel_i,
    input  logic [ADDR_W-1:0]  sw_wdata_i,
    input  logic [1:0]         rd_sel_i,
    output logic [ADDR_W-1:0]  rd_data_o,
    output logic               irq_take_o
);
    localparam int LEVELS = HW_IRQS + SW_IRQS;

    logic [LEVELS-1:0]  mask_w;
    logic [STACK_W-1:0] stack_w;
    logic [HW_IRQS-1:0] hw_pend_w;
    logic [SW_IRQS-1:0] sw_pend_w;
    logic [CODE_W-1:0]  code_w;
    logic [ADDR_W-1:0]  epc_w, bad_w;
    logic               wr_status, wr_cause, wr_epc;

    assign wr_status = sw_we_i && (sw_sel_i == SEL_STATUS);
    assign wr_cause  = sw_we_i && (sw_sel_i == SEL_CAUSE);
    assign wr_epc    = sw_we_i && (sw_sel_i == SEL_EPC);

    exc_status_reg #(.LEVELS(LEVELS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req_i  (exc_req_i),
        .rfe_i      (rfe_i),
        .wr_en_i    (wr_status),
        .wr_mask_i  (sw_wdata_i[MASK_LO +: LEVELS]),
        .wr_stack_i (sw_wdata_i[STACK_W-1:0]),
        .mask_o     (mask_w),
        .stack_o    (stack_w)
    );

    exc_cause_reg #(.HW_IRQS(HW_IRQS), .SW_IRQS(SW_IRQS), .CODE_W(CODE_W)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req_i  (exc_req_i),
        .code_i     (exc_code_i),
        .irq_i      (irq_i),
        .wr_en_i    (wr_cause),
        .wr_hw_i    (sw_wdata_i[PEND_LO + SW_IRQS +: HW_IRQS]),
        .wr_sw_i    (sw_wdata_i[PEND_LO +: SW_IRQS]),
        .hw_pend_o  (hw_pend_w),
        .sw_pend_o  (sw_pend_w),
        .code_o     (code_w)
    );

    exc_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req_i  (exc_req_i),
        .pc_next_i  (pc_next_i),
        .bad_vld_i  (bad_vld_i),
        .bad_addr_i (bad_addr_i),
        .epc_we_i   (wr_epc),
        .wr_data_i  (sw_wdata_i),
        .epc_o      (epc_w),
        .bad_o      (bad_w)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (rd_sel_i)
            SEL_STATUS: begin
                rd_data_o[MASK_LO +: LEVELS] = mask_w;
                rd_data_o[STACK_W-1:0]       = stack_w;
            end
            SEL_CAUSE: begin
                rd_data_o[PEND_LO +: LEVELS] = {hw_pend_w, sw_pend_w};
                rd_data_o[CODE_LO +: CODE_W] = code_w;
            end
            SEL_EPC:     rd_data_o = epc_w;
            SEL_BADADDR: rd_data_o = bad_w;
            default:     rd_data_o = '0;
        endcase
    end

    assign irq_take_o = stack_w[0] & (|({hw_pend_w, sw_pend_w} & mask_w));
endmodule

// File: rtl/exc_regs_chk.sv
module exc_regs_chk #(
    parameter int ADDR_W  = 32,
    parameter int HW_IRQS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exc_req_i,
    input logic               rfe_i,
    input logic               sw_we_i,
    input logic [1:0]         sw_sel_i,
    input logic [ADDR_W-1:0]  pc_next_i,
    input logic [HW_IRQS-1:0] irq_i,
    input logic [5:0]         stack,
    input logic [HW_IRQS-1:0] hw_pend,
    input logic [ADDR_W-1:0]  epc,
    input logic               irq_take
);
    a_r2_push: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> stack == {$past(stack[3:0]), 2'b00});

    a_r3_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_i && !exc_req_i) |=> stack == {$past(stack[5:4]), $past(stack[5:2])});

    a_r4_epc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> epc == $past(pc_next_i) - ADDR_W'(4));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we_i && sw_sel_i == 2'd1 && !exc_req_i)
            |=> (hw_pend & $past(hw_pend)) == $past(hw_pend));

    a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i != '0) |=> (hw_pend & $past(irq_i)) == $past(irq_i));

    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !stack[0] |-> !irq_take);

    a_r9_epc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i && sw_we_i && sw_sel_i == 2'd2) |=> epc == $past(pc_next_i) - ADDR_W'(4));
endmodule

bind exc_regs_unit exc_regs_chk #(.ADDR_W(ADDR_W), .HW_IRQS(HW_IRQS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req_i (exc_req_i),
    .rfe_i     (rfe_i),
    .sw_we_i   (sw_we_i),
    .sw_sel_i  (sw_sel_i),
    .pc_next_i (pc_next_i),
    .irq_i     (irq_i),
    .stack     (stack_w),
    .hw_pend   (hw_pend_w),
    .epc       (epc_w),
    .irq_take  (irq_take_o)
);

// File: tb/tb_exc_regs_unit.sv
`timescale 1ns/1ps
module tb_exc_regs_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] pc_next = '0;
    logic        bad_vld = 1'b0;
    logic [31:0] bad_addr = '0;
    logic        rfe = 1'b0;
    logic [5:0]  irq = '0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq_take;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side model of the architectural state
    logic [7:0]  m_mask = '0;
    logic [5:0]  m_stack = '0;
    logic [5:0]  m_hw = '0;
    logic [1:0]  m_sw = '0;
    logic [3:0]  m_code = '0;
    logic [31:0] m_epc = '0;
    logic [31:0] m_bad = '0;

    always #2 clk = ~clk;

    exc_regs_unit dut (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
        .pc_next_i(pc_next), .bad_vld_i(bad_vld), .bad_addr_i(bad_addr),
        .rfe_i(rfe), .irq_i(irq), .sw_we_i(sw_we), .sw_sel_i(sw_sel),
        .sw_wdata_i(sw_wdata), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .irq_take_o(irq_take)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_take;
        rd_sel = 2'd0; #1; chk({tag, " status"}, rd_data, {16'h0, m_mask, 2'b00, m_stack});
        rd_sel = 2'd1; #1; chk({tag, " cause"}, rd_data, {16'h0, m_hw, m_sw, 2'b00, m_code, 2'b00});
        rd_sel = 2'd2; #1; chk({tag, " epc"}, rd_data, m_epc);
        rd_sel = 2'd3; #1; chk({tag, " badaddr"}, rd_data, m_bad);
        exp_take = m_stack[0] & (|({m_hw, m_sw} & m_mask));
        chk({tag, " take"}, {31'h0, irq_take}, {31'h0, exp_take});
    endtask

    // apply the driven inputs for one clock edge and update the model
    task automatic step();
        if (exc_req)     m_stack = {m_stack[3:0], 2'b00};
        else if (rfe)    m_stack = {m_stack[5:4], m_stack[5:2]};
        else if (sw_we && sw_sel == 2'd0) begin
            m_mask  = sw_wdata[15:8];
            m_stack = sw_wdata[5:0];
        end
        if (sw_we && sw_sel == 2'd1 && !exc_req) begin
            m_hw = m_hw & sw_wdata[15:10];
            m_sw = sw_wdata[9:8];
        end
        m_hw = m_hw | irq;
        if (exc_req) m_code = exc_code;
        if (exc_req)                      m_epc = pc_next - 32'd4;
        else if (sw_we && sw_sel == 2'd2) m_epc = sw_wdata;
        if (exc_req && bad_vld) m_bad = bad_addr;
        @(negedge clk);
        exc_req = 1'b0; bad_vld = 1'b0; rfe = 1'b0; irq = '0; sw_we = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        step();
    endtask

    task automatic trap(input logic [3:0] c, input logic [31:0] pc, input logic v, input logic [31:0] a);
        exc_req = 1'b1; exc_code = c; pc_next = pc; bad_vld = v; bad_addr = a;
        step();
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1");

        // R8: write masks per register
        wr(2'd0, 32'hFFFF_FFFF); check_all("R8");
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF); check_all("R8");
        wr(2'd2, 32'hDEAD_BEEF); check_all("R8");
        wr(2'd3, 32'h1234_5678); check_all("R8");
        wr(2'd1, 32'h0);

        // R2 / R3: full sweep of the mode stack
        for (int v = 0; v < 64; v++) begin
            wr(2'd0, 32'(v));
            trap(4'(v), 32'h1000 + 32'(v) * 4, 1'b0, 32'h0);
            check_all("R2");
            wr(2'd0, 32'(v));
            rfe = 1'b1; step();
            check_all("R3");
        end

        // R4: every code value, including PC wrap at zero
        for (int c = 0; c < 16; c++) begin
            trap(4'(c), (c == 0) ? 32'h0 : 32'h0040_0000 + 32'(c) * 32'h104, 1'b0, 32'h0);
            check_all("R4");
        end

        // R5: faulting address captured only with valid flag
        trap(4'd4, 32'h200, 1'b0, 32'hAAAA_0000); check_all("R5");
        trap(4'd5, 32'h300, 1'b1, 32'hBBBB_0004); check_all("R5");
        trap(4'd7, 32'h400, 1'b0, 32'hCCCC_0008); check_all("R5");

        // R6: sticky pending with interrupts disabled
        wr(2'd0, 32'h0000_FF00);
        wr(2'd1, 32'h0);
        for (int l = 0; l < 6; l++) begin
            irq = 6'(1 << l); step();
            check_all("R6");
        end
        sw_we = 1'b1; sw_sel = 2'd1; sw_wdata = 32'h0000_FB00; irq = 6'h01; step();
        check_all("R6");
        wr(2'd1, 32'h0); check_all("R6");

        // R7: every pending pattern against every mask
        for (int p = 0; p < 256; p++) begin
            wr(2'd1, {22'h0, 2'(p), 8'h0});
            irq = 6'(p >> 2); step();
            check_all("R7");
            for (int m = 0; m < 256; m++) begin
                wr(2'd0, {16'h0, 8'(m), 8'h01});
                n_chk++;
                if (irq_take !== (|(8'(p) & 8'(m)))) begin
                    n_fail++;
                    $display("FAIL R7: p=%02h m=%02h actual %0b expected %0b",
                             p, m, irq_take, |(8'(p) & 8'(m)));
                end
            end
            wr(2'd0, 32'h0000_FF00);
            chk("R7 disabled", {31'h0, irq_take}, 32'h0);
        end
        wr(2'd1, 32'h0);

        // R9: same-cycle priorities
        wr(2'd0, 32'h0000_0025);
        exc_req = 1'b1; exc_code = 4'd8; pc_next = 32'h5000;
        sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 32'h0000_AB3F; step();
        check_all("R9");
        wr(2'd0, 32'h0000_0039);
        exc_req = 1'b1; exc_code = 4'd9; pc_next = 32'h6000; rfe = 1'b1; step();
        check_all("R9");
        wr(2'd0, 32'h0000_0038);
        rfe = 1'b1; sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 32'h0000_FF3F; step();
        check_all("R9");
        exc_req = 1'b1; exc_code = 4'd10; pc_next = 32'h7008;
        sw_we = 1'b1; sw_sel = 2'd2; sw_wdata = 32'h1111_1111; step();
        check_all("R9");
        exc_req = 1'b1; exc_code = 4'd12; pc_next = 32'h800C;
        sw_we = 1'b1; sw_sel = 2'd1; sw_wdata = 32'h0000_0300; irq = 6'h20; step();
        check_all("R9");

        // R10: final read of every select
        check_all("R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule